// File: doc/BRIEF.md
# Encoder Edge-Rate Meter

This block reports how busy one encoder line is. It counts every transition of the line, rising and falling alike, during a fixed measurement window. When the window closes it publishes the total. The raw line is first passed through a two-flop synchronizer. It is then examined only on a slow sampling enable. A change of level is accepted only once enough consecutive samples agree, and each sample is compared with the last accepted level. A short spike therefore cannot create a transition.

Everything runs on one system clock. The sampling rate and the window length both come from clock enables that count system cycles. No derived clocks are used. At each window boundary, the running total is moved into the output register and the running count is restarted in the same clock cycle. A one-cycle strobe marks each new result. The defaults assume a 40 MHz clock: samples are taken at 400 kHz, and each window lasts 10 ms, which is 400000 cycles.

Top module: `enc_rate_meter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `count_o` is 0 and `count_valid_o` is 0.
- R2: The sampling enable is high for exactly one cycle in every `SAMPLE_DIV` system cycles.
- R3: `count_valid_o` pulses for exactly one cycle once every `WINDOW_CYCLES` cycles, and never in two consecutive cycles.
- R4: In the cycle after a window boundary, `count_o` holds the number of accepted transitions in the window that just ended. The running count restarts at that boundary. A transition accepted in the boundary cycle counts toward the new window.
- R5: Accepted transitions from low to high and from high to low each add one to the running count.
- R6: A new level is accepted only after `DEBOUNCE_LEN` consecutive samples all differ from the current accepted level. Any sample that equals the accepted level restarts this run. A pulse that spans fewer samples than that produces no transition.
- R7: The running count saturates at 2^`COUNT_W`-1 and does not wrap.
- R8: `count_o` holds its value in every cycle where `count_valid_o` is low.
- R9: The encoder input passes through two flops before it is sampled. The accepted level, which starts at 0 after reset, is updated from that synchronized value.
- R10: Reset is asserted asynchronously. The block leaves reset only after two rising clock edges have occurred with `rst_n_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| enc_i | input | 1 | Raw encoder line, asynchronous to the clock |
| count_o | output | COUNT_W | Transition count of the last completed window |
| count_valid_o | output | 1 | One-cycle strobe that marks an update of `count_o` |

## Verification
The assertions take two things for granted. First, the encoder line is asynchronous and may change at any time. Second, the window length and the sampling divider are both at least 2, so that each enable is a lone one-cycle pulse. The bench changes the line only on falling clock edges. It runs with a short window and a narrow counter, so that saturation, spikes of one and two samples, and steady square waves can all be seen within a few windows. It also applies a reset in the middle of a window, to show that the restart is clean.

// File: rtl/erm_pkg.sv
package erm_pkg;

  // Counter width that can hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned erm_cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic [1:0] {
    LVL_IDLE  = 2'd0,
    LVL_AGREE = 2'd1,
    LVL_FLIP  = 2'd2
  } lvl_step_e;

endpackage

// File: rtl/erm_sync2.sv
module erm_sync2 #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= RESET_VAL;
      hold_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;

endmodule

// File: rtl/erm_tick_gen.sv
module erm_tick_gen
  import erm_pkg::*;
#(
  parameter int unsigned PERIOD = 100
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic tick_o
);

  localparam int unsigned CW = erm_cnt_width(PERIOD);

  generate
    if (PERIOD < 2) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cnt_q <= '0;
        else          cnt_q <= cnt_d;
      end

      assign tick_o = wrap;

      // R2 R3
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/erm_debounce.sv
module erm_debounce
  import erm_pkg::*;
#(
  parameter int unsigned DEBOUNCE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sample_en_i,
  input  logic level_i,
  output logic edge_o
);

  localparam int unsigned AW = erm_cnt_width(DEBOUNCE_LEN);
  localparam logic [AW-1:0] LAST = AW'(DEBOUNCE_LEN - 1);

  logic          stable_q, stable_d;
  logic [AW-1:0] agree_q, agree_d;
  logic          edge_q, edge_d;
  lvl_step_e     step;

  always_comb begin
    step = LVL_IDLE;
    if (sample_en_i && (level_i != stable_q))
      step = (agree_q == LAST) ? LVL_FLIP : LVL_AGREE;
    stable_d = stable_q;
    agree_d  = agree_q;
    edge_d   = 1'b0;
    unique case (step)
      LVL_FLIP: begin
        stable_d = level_i;
        agree_d  = '0;
        edge_d   = 1'b1;
      end
      LVL_AGREE: agree_d = agree_q + 1'b1;
      default:   if (sample_en_i) agree_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stable_q <= 1'b0;
      agree_q  <= '0;
      edge_q   <= 1'b0;
    end else begin
      stable_q <= stable_d;
      agree_q  <= agree_d;
      edge_q   <= edge_d;
    end
  end

  assign edge_o = edge_q;

  // R6
  edge_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    edge_o |-> $past(sample_en_i));

  // R5 R6
  level_moves_with_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(stable_q) |-> edge_o);

endmodule

// File: rtl/erm_edge_tally.sv
module erm_edge_tally #(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               edge_i,
  input  logic               win_tick_i,
  output logic [COUNT_W-1:0] count_o,
  output logic               valid_o
);

  localparam logic [COUNT_W-1:0] TOP = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] run_q, run_d;
  logic [COUNT_W-1:0] out_q, out_d;
  logic               vld_q, vld_d;

  always_comb begin
    run_d = run_q;
    out_d = out_q;
    vld_d = 1'b0;
    if (win_tick_i) begin
      out_d = run_q;
      vld_d = 1'b1;
      run_d = edge_i ? COUNT_W'(1) : '0;
    end else if (edge_i && (run_q != TOP)) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign count_o = out_q;
  assign valid_o = vld_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_q == TOP && !win_tick_i) |=> run_q == TOP);

  // R4
  capture_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_o |-> $past(win_tick_i));

  // R8
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !valid_o |-> $stable(count_o));

endmodule

// File: rtl/enc_rate_meter.sv
module enc_rate_meter #(
  parameter int unsigned SAMPLE_DIV    = 100,
  parameter int unsigned WINDOW_CYCLES = 400000,
  parameter int unsigned DEBOUNCE_LEN  = 4,
  parameter int unsigned COUNT_W       = 16
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               enc_i,
  output logic [COUNT_W-1:0] count_o,
  output logic               count_valid_o
);

  logic rst_n_int;
  logic enc_sync;
  logic sample_en;
  logic win_tick;
  logic edge_seen;

  // R10: asynchronous assert, release after two clock edges
  erm_sync2 #(.RESET_VAL(1'b0)) i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (1'b1),
    .q_o     (rst_n_int)
  );

  // R9: two-flop input synchronizer
  erm_sync2 #(.RESET_VAL(1'b0)) i_enc_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_int),
    .d_i     (enc_i),
    .q_o     (enc_sync)
  );

  erm_tick_gen #(.PERIOD(SAMPLE_DIV)) i_sample_tick (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_int),
    .tick_o  (sample_en)
  );

  erm_tick_gen #(.PERIOD(WINDOW_CYCLES)) i_window_tick (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_int),
    .tick_o  (win_tick)
  );

  erm_debounce #(.DEBOUNCE_LEN(DEBOUNCE_LEN)) i_debounce (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_int),
    .sample_en_i (sample_en),
    .level_i     (enc_sync),
    .edge_o      (edge_seen)
  );

  erm_edge_tally #(.COUNT_W(COUNT_W)) i_tally (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_int),
    .edge_i     (edge_seen),
    .win_tick_i (win_tick),
    .count_o    (count_o),
    .valid_o    (count_valid_o)
  );

  // R3
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    count_valid_o |=> !count_valid_o);

  // R1 R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_n_int |-> (count_o == '0 && !count_valid_o));

endmodule

// File: tb/test_enc_rate_meter.sv
module test_enc_rate_meter;

  localparam int unsigned DIV = 4;
  localparam int unsigned WIN = 240;
  localparam int unsigned DEB = 3;
  localparam int unsigned CW  = 4;
  localparam int          TOPV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc = 1'b0;
  logic [CW-1:0] count;
  logic          valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mode = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  enc_rate_meter #(
    .SAMPLE_DIV(DIV), .WINDOW_CYCLES(WIN), .DEBOUNCE_LEN(DEB), .COUNT_W(CW)
  ) i_enc_rate_meter (
    .clk_i(clk), .rst_n_i(rst_n), .enc_i(enc),
    .count_o(count), .count_valid_o(valid)
  );

  // Behavioural reference state
  int m_r1, m_r2, m_s1, m_s2, m_sc, m_wc, m_lvl, m_run, m_edge, m_out, m_vld;
  int m_same;

  task automatic model_clear();
    m_s1 = 0; m_s2 = 0; m_sc = 0; m_wc = 0; m_lvl = 0; m_same = 0;
    m_run = 0; m_edge = 0; m_out = 0; m_vld = 0;
  endtask

  initial begin
    m_r1 = 0; m_r2 = 0;
    model_clear();
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      model_clear();
    end else if (m_r2 == 0) begin
      m_r2 = m_r1; m_r1 = 1;
      model_clear();
    end else begin
      int smp, win, nedge, lvl_in;
      lvl_in = m_s2;
      m_s2 = m_s1; m_s1 = enc;
      smp = (m_sc == DIV - 1); m_sc = smp ? 0 : m_sc + 1;
      win = (m_wc == WIN - 1); m_wc = win ? 0 : m_wc + 1;
      nedge = 0;
      if (smp) begin
        if (lvl_in != m_lvl) begin
          m_same++;
          if (m_same == DEB) begin m_lvl = lvl_in; m_same = 0; nedge = 1; end
        end else m_same = 0;
      end
      if (win) begin
        m_out = m_run; m_vld = 1; m_run = m_edge;
      end else begin
        m_vld = 0;
        if (m_edge && m_run < TOPV) m_run++;
      end
      m_edge = nedge;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " count"}, int'(count), m_out);
      check("R3 valid", int'(valid), m_vld);
    end
  end

  // Stimulus generator driven by mode
  int ph = 0;
  always @(negedge clk) begin
    ph++;
    case (mode)
      1: if (ph % 40 == 0) enc <= ~enc;           // slow square wave
      2: enc <= ((ph % 50) < 4) || ((ph % 50) >= 25 && (ph % 50) < 33); // 1- and 2-sample spikes
      3: if (ph % 12 == 0) enc <= ~enc;           // fast toggling
      default: enc <= 1'b0;
    endcase
  end

  task automatic wait_valids(input int n, input int min_exp, input int exact, input string req);
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!valid);
      if (k >= 1) begin
        if (exact >= 0) check(req, int'(count), exact);
        if (min_exp >= 0) begin
          checks++;
          if (int'(count) < min_exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected >= %0d", req, count, min_exp);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_n <= 1'b1;
    @(negedge clk);
    check("R10 held after release", int'(count), 0);
    tag = "R8";  mode = 0; wait_valids(2, -1, 0, "R4 quiet window");
    tag = "R5";  mode = 1; wait_valids(3, 5, -1, "R5 both edges counted");
    tag = "R6";  mode = 2; enc <= 1'b0; wait_valids(3, -1, 0, "R6 spikes rejected");
    tag = "R7";  mode = 3; wait_valids(3, -1, TOPV, "R7 saturation");
    mode = 0;
    repeat (37) @(negedge clk);
    rst_n <= 1'b0;
    @(negedge clk);
    check("R10 async reset count", int'(count), 0);
    check("R10 async reset valid", int'(valid), 0);
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    tag = "R9"; mode = 1; wait_valids(3, 5, -1, "R9 after mid-run reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule